// File: doc/BRIEF.md
# Debug Control Register with Task-Switch Clearing

This block holds the debug control word of a processor core. The word has a global and a local enable for each hardware breakpoint, a global and a local exact-match bit, and a protection bit. The execution pipeline sends register requests to the block. Each request carries a read/write flag, a select that says whether it targets this control word or one of the other debug registers, and the requester's mode (real mode flag and privilege level). Each request gets a registered response one cycle later. The response carries either read data or one of two fault indications.

Two event pulses from the core clear fields automatically. A task switch drops all local enables and the local exact-match bit, and leaves every global bit as it was. Entry into the debug exception handler drops the protection bit, so the handler can reach the debug registers.

The block drives the effective per-breakpoint enables to the address comparators and an exact-match request to the pipeline. The exact-match request tells the pipeline to wait for operand transfers to finish before it starts the next instruction.

Top module: `dbg_ctl_reg`

## Requirements
- R1: After reset, all local enables, global enables, both exact-match bits and the protection bit are zero, and no response is pending.
- R2: A request is permitted only when the real-mode flag is 1 or the privilege level is 0. Any other request gets `rsp_deny_o` = 1 in the following cycle. A privilege denial takes priority over a protection fault.
- R3: While the protection bit (bit 10) is 1, every permitted-mode request raises `rsp_prot_fault_o` one cycle later. This holds for reads and writes, whether or not the request selects this register.
- R4: A pulse on `handler_entry_i` clears the protection bit at the next clock edge.
- R5: A pulse on `task_switch_i` clears local enables bits 3:0 and the local exact-match bit 8 at the next edge.
- R6: A task switch leaves global enables bits 7:4 and the global exact-match bit 9 unchanged.
- R7: `bp_en_o[i]` is 1 exactly when global enable i or local enable i is 1.
- R8: `exact_req_o` is 1 when either exact-match bit is 1.
- R9: A blocked request (denied or protection fault) changes no bit of the register, and its response data is zero.
- R10: When a permitted write and a task switch occur in the same cycle, the write is applied first and the local fields are then cleared. The written global fields are kept.
- R11: A permitted read of this register returns, one cycle later with `rsp_valid_o` = 1, the word with this layout: local enables in bits 3:0, global enables in 7:4, local exact in 8, global exact in 9, protection in 10, and all other bits zero. Writes and non-selected reads return zero data.
- R12: A permitted request with `acc_sel_ctl_i` = 0 does not change this register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Request present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_sel_ctl_i | input | 1 | Request targets the control word (0 = another debug register) |
| acc_real_mode_i | input | 1 | Requester is in real mode |
| acc_priv_i | input | PRIV_W | Requester privilege level |
| acc_wdata_i | input | DATA_W | Write data |
| task_switch_i | input | 1 | Task-switch pulse |
| handler_entry_i | input | 1 | Debug handler entry pulse |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rdata_o | output | DATA_W | Read data, zero when blocked |
| rsp_deny_o | output | 1 | Request refused for mode or privilege |
| rsp_prot_fault_o | output | 1 | Request refused by the protection bit |
| bp_en_o | output | NUM_BP | Effective breakpoint enables |
| exact_req_o | output | 1 | Exact data-match request to the pipeline |

## Verification
The assertions assume that the event pulses and requests are sampled only at clock edges, and that no register changes except through a permitted selected write or one of the two event pulses. For that reason, the hold check is written only for cycles with no write and no event. The stimulus drives each request or pulse for exactly one cycle from the falling edge and then returns all inputs to idle. That keeps every response tied to exactly one request. It also lets the scoreboard queue match responses in order.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

    // Outcome of the permission check for one request
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_OK   = 2'd1,
        ACC_DENY = 2'd2,
        ACC_PROT = 2'd3
    } acc_cause_e;

    localparam int NUM_BP_DEF = 4;
    localparam int DATA_W_DEF = 32;
    localparam int PRIV_W_DEF = 2;

endpackage

// File: rtl/dbgc_access_guard.sv
module dbgc_access_guard
    import dbgc_pkg::*;
#(
    parameter int PRIV_W = PRIV_W_DEF
) (
    input  logic              req_valid,
    input  logic              req_real_mode,
    input  logic [PRIV_W-1:0] req_priv,
    input  logic              protect_on,
    output acc_cause_e        cause
);

    logic mode_ok;

    always_comb begin
        mode_ok = req_real_mode || (req_priv == '0);
        if (!req_valid) begin
            cause = ACC_NONE;
        end else if (!mode_ok) begin
            cause = ACC_DENY;            // privilege refusal wins
        end else if (protect_on) begin
            cause = ACC_PROT;
        end else begin
            cause = ACC_OK;
        end
    end

endmodule

// File: rtl/dbgc_ctl_state.sv
module dbgc_ctl_state #(
    parameter int NUM_BP = dbgc_pkg::NUM_BP_DEF,
    parameter int DATA_W = dbgc_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              task_switch,
    input  logic              handler_entry,
    output logic [NUM_BP-1:0] loc_en,
    output logic [NUM_BP-1:0] glb_en,
    output logic              loc_exact,
    output logic              glb_exact,
    output logic              protect,
    output logic [DATA_W-1:0] image
);

    localparam int GLB_LSB = NUM_BP;
    localparam int LE_BIT  = 2 * NUM_BP;
    localparam int GE_BIT  = LE_BIT + 1;
    localparam int GD_BIT  = GE_BIT + 1;

    typedef struct packed {
        logic [NUM_BP-1:0] loc;
        logic [NUM_BP-1:0] glb;
        logic              le;
        logic              ge;
        logic              gd;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:GD_BIT+1];

    always_comb begin
        ctl_d = ctl_q;
        // write lands first, then the event clears override it
        if (wr_en) begin
            ctl_d.loc = wdata[NUM_BP-1:0];
            ctl_d.glb = wdata[GLB_LSB +: NUM_BP];
            ctl_d.le  = wdata[LE_BIT];
            ctl_d.ge  = wdata[GE_BIT];
            ctl_d.gd  = wdata[GD_BIT];
        end
        if (task_switch) begin
            ctl_d.loc = '0;
            ctl_d.le  = 1'b0;
        end
        if (handler_entry) begin
            ctl_d.gd = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        image                      = '0;
        image[NUM_BP-1:0]          = ctl_q.loc;
        image[GLB_LSB +: NUM_BP]   = ctl_q.glb;
        image[LE_BIT]              = ctl_q.le;
        image[GE_BIT]              = ctl_q.ge;
        image[GD_BIT]              = ctl_q.gd;
    end

    assign loc_en    = ctl_q.loc;
    assign glb_en    = ctl_q.glb;
    assign loc_exact = ctl_q.le;
    assign glb_exact = ctl_q.ge;
    assign protect   = ctl_q.gd;

    AST_TS_CLEARS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> (ctl_q.loc == '0 && !ctl_q.le)); // R5

    AST_TS_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (task_switch && !wr_en) |=> ($stable(ctl_q.glb) && $stable(ctl_q.ge))); // R6

    AST_HANDLER_DROPS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        handler_entry |=> !ctl_q.gd); // R4

    AST_WRITE_BEFORE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && task_switch) |=> (ctl_q.glb == $past(wdata[GLB_LSB +: NUM_BP]))); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !task_switch && !handler_entry) |=> $stable(ctl_q)); // R9

endmodule

// File: rtl/dbgc_enable_merge.sv
module dbgc_enable_merge #(
    parameter int NUM_BP = dbgc_pkg::NUM_BP_DEF
) (
    input  logic [NUM_BP-1:0] loc_en,
    input  logic [NUM_BP-1:0] glb_en,
    input  logic              loc_exact,
    input  logic              glb_exact,
    output logic [NUM_BP-1:0] bp_en,
    output logic              exact_req
);

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        assign bp_en[i] = glb_en[i] | loc_en[i];
    end

    assign exact_req = loc_exact | glb_exact;

endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
    import dbgc_pkg::*;
#(
    parameter int NUM_BP = NUM_BP_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int PRIV_W = PRIV_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic              acc_sel_ctl_i,
    input  logic              acc_real_mode_i,
    input  logic [PRIV_W-1:0] acc_priv_i,
    input  logic [DATA_W-1:0] acc_wdata_i,
    input  logic              task_switch_i,
    input  logic              handler_entry_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              rsp_deny_o,
    output logic              rsp_prot_fault_o,
    output logic [NUM_BP-1:0] bp_en_o,
    output logic              exact_req_o
);

    typedef struct packed {
        logic              valid;
        logic              deny;
        logic              prot;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t              rsp_d, rsp_q;
    acc_cause_e        cause;
    logic              wr_en;
    logic [NUM_BP-1:0] loc_en, glb_en;
    logic              loc_exact, glb_exact, protect;
    logic [DATA_W-1:0] st_image;

    dbgc_access_guard #(.PRIV_W(PRIV_W)) u_guard (
        .req_valid     (acc_valid_i),
        .req_real_mode (acc_real_mode_i),
        .req_priv      (acc_priv_i),
        .protect_on    (protect),
        .cause         (cause)
    );

    assign wr_en = (cause == ACC_OK) && acc_write_i && acc_sel_ctl_i;

    dbgc_ctl_state #(.NUM_BP(NUM_BP), .DATA_W(DATA_W)) u_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wdata         (acc_wdata_i),
        .task_switch   (task_switch_i),
        .handler_entry (handler_entry_i),
        .loc_en        (loc_en),
        .glb_en        (glb_en),
        .loc_exact     (loc_exact),
        .glb_exact     (glb_exact),
        .protect       (protect),
        .image         (st_image)
    );

    dbgc_enable_merge #(.NUM_BP(NUM_BP)) u_merge (
        .loc_en    (loc_en),
        .glb_en    (glb_en),
        .loc_exact (loc_exact),
        .glb_exact (glb_exact),
        .bp_en     (bp_en_o),
        .exact_req (exact_req_o)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = acc_valid_i;
        rsp_d.deny  = (cause == ACC_DENY);
        rsp_d.prot  = (cause == ACC_PROT);
        if (cause == ACC_OK && acc_sel_ctl_i && !acc_write_i) begin
            rsp_d.rdata = st_image;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o      = rsp_q.valid;
    assign rsp_rdata_o      = rsp_q.rdata;
    assign rsp_deny_o       = rsp_q.deny;
    assign rsp_prot_fault_o = rsp_q.prot;

    AST_MODE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !acc_real_mode_i && acc_priv_i != '0) |=> rsp_deny_o); // R2

    AST_PROT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && (acc_real_mode_i || acc_priv_i == '0) && protect)
        |=> rsp_prot_fault_o); // R3

    AST_BLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && (rsp_deny_o || rsp_prot_fault_o)) |-> (rsp_rdata_o == '0)); // R9

    AST_BLOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && cause != ACC_OK && !task_switch_i && !handler_entry_i)
        |=> $stable(st_image)); // R9

    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $onehot0({rsp_deny_o, rsp_prot_fault_o})); // R2

endmodule

// File: tb/dbg_ctl_reg_bench.sv
module dbg_ctl_reg_bench;

    localparam int NBP = 4;
    localparam int DW  = 32;
    localparam int PW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid_i = 1'b0, acc_write_i = 1'b0, acc_sel_ctl_i = 1'b0;
    logic          acc_real_mode_i = 1'b0;
    logic [PW-1:0] acc_priv_i = '0;
    logic [DW-1:0] acc_wdata_i = '0;
    logic          task_switch_i = 1'b0, handler_entry_i = 1'b0;
    logic          rsp_valid_o, rsp_deny_o, rsp_prot_fault_o, exact_req_o;
    logic [DW-1:0] rsp_rdata_o;
    logic [NBP-1:0] bp_en_o;

    always #10 clk = ~clk;   // 50 MHz

    dbg_ctl_reg u_dbg_ctl_reg (
        .clk(clk), .rst_n(rst_n),
        .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
        .acc_sel_ctl_i(acc_sel_ctl_i), .acc_real_mode_i(acc_real_mode_i),
        .acc_priv_i(acc_priv_i), .acc_wdata_i(acc_wdata_i),
        .task_switch_i(task_switch_i), .handler_entry_i(handler_entry_i),
        .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
        .rsp_deny_o(rsp_deny_o), .rsp_prot_fault_o(rsp_prot_fault_o),
        .bp_en_o(bp_en_o), .exact_req_o(exact_req_o)
    );

    typedef struct {
        logic          deny;
        logic          prot;
        logic [DW-1:0] rdata;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    // reference model of the register
    logic [3:0] m_loc = '0, m_glb = '0;
    logic       m_le = 1'b0, m_ge = 1'b0, m_gd = 1'b0;

    function automatic logic [DW-1:0] m_image();
        logic [DW-1:0] v = '0;
        v[3:0] = m_loc; v[7:4] = m_glb; v[8] = m_le; v[9] = m_ge; v[10] = m_gd;
        return v;
    endfunction

    task automatic drive(input bit has_acc, input bit wr, input bit sel, input bit rm,
                         input bit [PW-1:0] pr, input logic [DW-1:0] wd,
                         input bit ts, input bit he, input string tag);
        exp_t e;
        bit allowed, ok;
        @(negedge clk); #1;
        acc_valid_i = has_acc; acc_write_i = wr; acc_sel_ctl_i = sel;
        acc_real_mode_i = rm; acc_priv_i = pr; acc_wdata_i = wd;
        task_switch_i = ts; handler_entry_i = he;
        allowed = rm || (pr == 0);
        ok      = allowed && !m_gd;
        if (has_acc) begin
            e.deny  = !allowed;
            e.prot  = allowed && m_gd;
            e.rdata = (ok && sel && !wr) ? m_image() : '0;
            e.tag   = tag;
            exp_q.push_back(e);
        end
        if (has_acc && ok && wr && sel) begin
            m_loc = wd[3:0]; m_glb = wd[7:4]; m_le = wd[8]; m_ge = wd[9]; m_gd = wd[10];
        end
        if (ts) begin m_loc = '0; m_le = 1'b0; end
        if (he) m_gd = 1'b0;
        @(negedge clk); #1;
        acc_valid_i = 1'b0; acc_write_i = 1'b0; task_switch_i = 1'b0; handler_entry_i = 1'b0;
    endtask

    task automatic chk_state(input string tag);
        logic [3:0] eb;
        logic       ex;
        eb = m_glb | m_loc;
        ex = m_le | m_ge;
        n_checks++;
        if (bp_en_o !== eb || exact_req_o !== ex) begin
            n_fail++;
            $display("FAIL %s: bp_en=%b exact=%b expected bp_en=%b exact=%b",
                     tag, bp_en_o, exact_req_o, eb, ex);
        end
    endtask

    // monitor: pop expected responses as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid_o) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R11: unexpected response rdata=%h", rsp_rdata_o);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (rsp_deny_o !== e.deny || rsp_prot_fault_o !== e.prot ||
                        rsp_rdata_o !== e.rdata) begin
                        n_fail++;
                        $display("FAIL %s: deny=%b prot=%b rdata=%h expected deny=%b prot=%b rdata=%h",
                                 e.tag, rsp_deny_o, rsp_prot_fault_o, rsp_rdata_o,
                                 e.deny, e.prot, e.rdata);
                    end
                end
            end else if (exp_q.size() != 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL %s: response missing, got valid=0 expected valid=1", exp_q[0].tag);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        n_checks++;
        if (rsp_valid_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: rsp_valid=%b expected 0", rsp_valid_o);
        end
        chk_state("R1 reset enables");
        drive(1, 0, 1, 1, 0, '0, 0, 0, "R1 reset read");

        // R11, R7, R8: write then read layout
        drive(1, 1, 1, 0, 0, 32'h125, 0, 0, "R11 write ack");
        drive(1, 0, 1, 0, 0, '0, 0, 0, "R11 read back");
        chk_state("R7 R8 merge");

        // R2, R9: denied write and read from privilege 3
        drive(1, 1, 1, 0, 3, 32'h7FF, 0, 0, "R2 denied write");
        drive(1, 0, 1, 0, 3, '0, 0, 0, "R9 denied read zero");
        drive(1, 0, 1, 0, 0, '0, 0, 0, "R9 unchanged after deny");

        // R2: real mode permits any privilege; R8 global exact only
        drive(1, 1, 1, 1, 3, 32'h200, 0, 0, "R2 real mode write");
        chk_state("R8 global exact only");

        // R5, R6: task switch alone
        drive(1, 1, 1, 0, 0, 32'h3C3, 0, 0, "R5 setup write");
        drive(0, 0, 0, 0, 0, '0, 1, 0, "R5 task switch");
        chk_state("R5 R6 after task switch");
        drive(1, 0, 1, 0, 0, '0, 0, 0, "R6 globals kept");

        // R10: write and task switch together
        drive(1, 1, 1, 0, 0, 32'h1FF, 1, 0, "R10 write+switch");
        drive(1, 0, 1, 0, 0, '0, 0, 0, "R10 read");
        chk_state("R10 enables");

        // R3, R9, R12: protection bit active
        drive(1, 1, 1, 0, 0, 32'h4F0, 0, 0, "R3 set protect");
        drive(1, 0, 1, 0, 0, '0, 0, 0, "R3 protected read");
        drive(1, 1, 1, 0, 0, 32'h000, 0, 0, "R9 protected write");
        chk_state("R9 no change under protect");
        drive(1, 0, 0, 1, 0, '0, 0, 0, "R3 other register faults");
        drive(1, 0, 1, 0, 2, '0, 0, 0, "R2 deny priority");

        // R4: handler entry clears protection
        drive(0, 0, 0, 0, 0, '0, 0, 1, "R4 handler entry");
        drive(1, 0, 1, 0, 0, '0, 0, 0, "R4 read after entry");

        // R12: non-selected accesses leave this register alone
        drive(1, 1, 0, 0, 0, 32'h000, 0, 0, "R12 other write");
        drive(1, 0, 0, 0, 0, '0, 0, 0, "R12 other read");
        drive(1, 0, 1, 0, 0, '0, 0, 0, "R12 unchanged");
        chk_state("R12 enables");

        // R5 with handler entry in same cycle
        drive(0, 0, 0, 0, 0, '0, 1, 1, "R5 combined events");
        chk_state("R5 combined");
        drive(1, 0, 1, 0, 0, '0, 0, 0, "R6 final read");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule